// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between a memory bus and a page write controller. It watches every qualified byte write, given as a 15-bit address and an 8-bit data value, and looks for fixed command patterns aimed at fixed addresses. Some patterns arm a write-protection mode and others clear it. For each write, the block decides in the same cycle whether the byte goes on to be programmed (`pass_o`) or is held back as a command byte (`cmd_o`). A write with neither flag is discarded.

The unlock prefix is three writes: 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. When the prefix is followed by an ordinary write, that write is programmed and protection turns on. While protection is on, each data write must come directly after its own unlock prefix. The clear sequence is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. The protection flag is a plain register that reset clears.

Top module: `sw_wprot_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `protect_o` is 0. A plain write after reset passes (`pass_o`=1).
- R2: The prefix bytes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, written in order, each give `cmd_o`=1 and `pass_o`=0. Only that exact data at that exact address advances the match.
- R3: The prefix on its own leaves `protect_o` unchanged. The next write after a complete prefix, whatever its address and data, gives `pass_o`=1, and `protect_o` is 1 from the following cycle.
- R4: While `protect_o` is 1, a write that is not a sequence byte and does not directly follow a complete prefix gives `pass_o`=0 and `cmd_o`=0.
- R5: While `protect_o` is 1, a write that directly follows a complete prefix passes, and `protect_o` stays 1.
- R6: The six-byte clear sequence gives `cmd_o`=1 and `pass_o`=0 on every byte. `protect_o` is 0 from the cycle after the last byte.
- R7: A write that breaks a partly matched sequence gives `cmd_o`=0 and returns the sequencer to idle, without starting a new match itself. It passes when protection is off and is discarded when protection is on.
- R8: With protection off, a write that matches no sequence step passes. With `wr_valid_i` low, both `pass_o` and `cmd_o` are 0.
- R9: The clear sequence written while protection is off still masks all six bytes, and `protect_o` stays 0.
- R10: Matching uses all 15 address bits and all 8 data bits. An address that differs from 0x5555 in any bit does not start a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Qualified byte write event |
| wr_addr_i | input | 15 | Write address |
| wr_data_i | input | 8 | Write data |
| pass_o | output | 1 | Write is forwarded to the page write controller |
| cmd_o | output | 1 | Write is a command byte and is suppressed |
| protect_o | output | 1 | Write-protection mode is active |

## Verification
Two things can land in the same cycle. One is the write that finishes an armed prefix: it is both forwarded as data and the trigger that sets `protect_o` at that same edge. The other is the last byte of the clear sequence, which is masked in the cycle that drops `protect_o`. The bench checks the gating outputs while the write is present and checks `protect_o` one cycle later, so each side of the coincidence is judged on its own. Sweeps over every address for the first byte and every data value for the second and third bytes show that only the exact patterns advance the match, and that a breaking write never starts a new one.

// File: rtl/wprot_seq_pkg.sv
package wprot_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_ARM,
    ST_D3,
    ST_D4,
    ST_D5
  } seq_st_e;

  typedef struct packed {
    logic k_aa;  // 0xAA at primary address
    logic k_55;  // 0x55 at secondary address
    logic k_a0;  // 0xA0 at primary address
    logic k_80;  // 0x80 at primary address
    logic k_20;  // 0x20 at primary address
  } tok_t;
endpackage

// File: rtl/wprot_tok_dec.sv
module wprot_tok_dec
  import wprot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_S = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_AA = 8'hAA,
  parameter logic [DATA_W-1:0] D_55 = 8'h55,
  parameter logic [DATA_W-1:0] D_A0 = 8'hA0,
  parameter logic [DATA_W-1:0] D_80 = 8'h80,
  parameter logic [DATA_W-1:0] D_20 = 8'h20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output tok_t              tok_o
);
  logic at_p, at_s;

  assign at_p = (addr_i == ADDR_P);
  assign at_s = (addr_i == ADDR_S);

  always_comb begin
    tok_o.k_aa = at_p && (data_i == D_AA);
    tok_o.k_55 = at_s && (data_i == D_55);
    tok_o.k_a0 = at_p && (data_i == D_A0);
    tok_o.k_80 = at_p && (data_i == D_80);
    tok_o.k_20 = at_p && (data_i == D_20);
  end
endmodule

// File: rtl/wprot_fsm.sv
module wprot_fsm
  import wprot_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  tok_t tok_i,
  input  logic prot_i,
  output logic pass_o,
  output logic cmd_o,
  output logic set_o,
  output logic clr_o
);
  seq_st_e st_q, st_d;
  logic    hit;

  always_comb begin
    st_d  = st_q;
    hit   = 1'b0;
    set_o = 1'b0;
    clr_o = 1'b0;
    case (st_q)
      ST_IDLE: if (tok_i.k_aa) begin hit = 1'b1; st_d = ST_K1; end
      ST_K1:   if (tok_i.k_55) begin hit = 1'b1; st_d = ST_K2; end
      ST_K2: begin
        if (tok_i.k_a0) begin hit = 1'b1; st_d = ST_ARM; end
        else if (tok_i.k_80) begin hit = 1'b1; st_d = ST_D3; end
      end
      ST_ARM:  begin hit = 1'b1; set_o = valid_i; st_d = ST_IDLE; end
      ST_D3:   if (tok_i.k_aa) begin hit = 1'b1; st_d = ST_D4; end
      ST_D4:   if (tok_i.k_55) begin hit = 1'b1; st_d = ST_D5; end
      ST_D5:   if (tok_i.k_20) begin hit = 1'b1; clr_o = valid_i; st_d = ST_IDLE; end
      default: st_d = ST_IDLE;
    endcase
    if (!hit) st_d = ST_IDLE;
    if (!valid_i) st_d = st_q;
  end

  // armed write is data; every other hit is a command byte
  assign cmd_o  = valid_i && hit && (st_q != ST_ARM);
  assign pass_o = valid_i && ((st_q == ST_ARM) || (!hit && !prot_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/wprot_flag.sv
module wprot_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prot_o <= 1'b0;
    else if (set_i) prot_o <= 1'b1;
    else if (clr_i) prot_o <= 1'b0;
  end
endmodule

// File: rtl/sw_wprot_seq.sv
module sw_wprot_seq
  import wprot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pass_o,
  output logic              cmd_o,
  output logic              protect_o
);
  tok_t tok;
  logic set_p, clr_p;

  wprot_tok_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .tok_o (tok)
  );

  wprot_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(wr_valid_i),
    .tok_i  (tok),
    .prot_i (protect_o),
    .pass_o (pass_o),
    .cmd_o  (cmd_o),
    .set_o  (set_p),
    .clr_o  (clr_p)
  );

  wprot_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_p),
    .clr_i (clr_p),
    .prot_o(protect_o)
  );
endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              pass_o,
  input logic              cmd_o,
  input logic              protect_o
);
  logic last_a0_q;
  logic last_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_a0_q  <= 1'b0;
      last_end_q <= 1'b0;
    end else if (wr_valid_i) begin
      last_a0_q  <= cmd_o && (wr_data_i == 8'hA0);
      last_end_q <= cmd_o && (wr_data_i == 8'h20);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> (!pass_o && !cmd_o)); // R8
  AST_CMD_NOT_PASSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> !pass_o); // R2
  AST_PROT_ON_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_o) |-> $past(pass_o && last_a0_q)); // R3
  AST_PROT_OFF_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protect_o) |-> $past(last_end_q == 1'b0 && cmd_o && wr_data_i == 8'h20)); // R6
  AST_PROT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o && pass_o) |-> last_a0_q); // R4
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o && pass_o) |=> protect_o); // R5
endmodule

bind sw_wprot_seq wprot_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .pass_o    (pass_o),
  .cmd_o     (cmd_o),
  .protect_o (protect_o)
);

// File: tb/sw_wprot_seq_bench.sv
module sw_wprot_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [14:0] a = '0;
  logic [7:0]  d = '0;
  logic        pass, cmd, prot;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  localparam logic [14:0] AP = 15'h5555;
  localparam logic [14:0] AS = 15'h2AAA;

  always #5 clk = ~clk;

  sw_wprot_seq u_sw_wprot_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(v), .wr_addr_i(a), .wr_data_i(d),
    .pass_o(pass), .cmd_o(cmd), .protect_o(prot)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] wa, input logic [7:0] wd,
                    input bit ep, input bit ec, input string req);
    @(negedge clk);
    v = 1'b1; a = wa; d = wd;
    #2;
    chk(pass == ep, {req, " pass"}, pass, ep);
    chk(cmd == ec, {req, " cmd"}, cmd, ec);
    @(posedge clk);
    #1 v = 1'b0;
  endtask

  task automatic chk_prot(input bit e, input string req);
    @(negedge clk);
    chk(prot == e, {req, " protect"}, prot, e);
  endtask

  task automatic prefix(input string req);
    wr(AP, 8'hAA, 0, 1, req);
    wr(AS, 8'h55, 0, 1, req);
    wr(AP, 8'hA0, 0, 1, req);
  endtask

  task automatic unlock_clear(input string req);
    wr(AP, 8'hAA, 0, 1, req);
    wr(AS, 8'h55, 0, 1, req);
    wr(AP, 8'h80, 0, 1, req);
    wr(AP, 8'hAA, 0, 1, req);
    wr(AS, 8'h55, 0, 1, req);
    wr(AP, 8'h20, 0, 1, req);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #23;
    chk(prot == 1'b0, "R1 reset protect", prot, 0);
    chk(!pass && !cmd, "R8 idle outputs", {pass, cmd}, 0);
    @(negedge clk) rst_n = 1'b1;
    chk_prot(0, "R1");
    wr(15'h0100, 8'h12, 1, 0, "R1 first write");

    // R10: every address for the first byte
    for (int i = 0; i < 32768; i++) begin
      wr(15'(i), 8'hAA, (i != 32'h5555), (i == 32'h5555), "R10 addr sweep");
      if (i == 32'h5555) wr(15'h0200, 8'h00, 1, 0, "R7 break unprot");
    end

    // R2: every data value for the second byte
    for (int i = 0; i < 256; i++) begin
      wr(AP, 8'hAA, 0, 1, "R2");
      wr(AS, 8'(i), (i != 8'h55), (i == 8'h55), "R2 byte2 sweep");
      if (i == 8'h55) wr(15'h0300, 8'h01, 1, 0, "R7 break unprot");
    end

    // R2: every data value for the third byte (A0 handled below)
    for (int i = 0; i < 256; i++) begin
      if (i == 8'hA0) continue;
      wr(AP, 8'hAA, 0, 1, "R2");
      wr(AS, 8'h55, 0, 1, "R2");
      wr(AP, 8'(i), (i != 8'h80), (i == 8'h80), "R2 byte3 sweep");
      if (i == 8'h80) wr(15'h0301, 8'h02, 1, 0, "R7 break unprot");
    end
    chk_prot(0, "R8");

    unlock_clear("R9");
    chk_prot(0, "R9");

    prefix("R3");
    chk_prot(0, "R3 prefix alone");
    wr(15'h0400, 8'h5A, 1, 0, "R3 armed write");
    chk_prot(1, "R3");

    wr(15'h0401, 8'h11, 0, 0, "R4 unguarded");
    wr(AS, 8'h55, 0, 0, "R4 stray cmd");
    chk_prot(1, "R4");

    prefix("R5");
    wr(15'h0402, 8'h22, 1, 0, "R5 guarded");
    chk_prot(1, "R5");
    wr(15'h0403, 8'h23, 0, 0, "R5 one write per prefix");

    // break while protected, no restart on the breaking write
    wr(AP, 8'hAA, 0, 1, "R7");
    wr(AS, 8'h55, 0, 1, "R7");
    wr(AP, 8'hAA, 0, 0, "R7 break prot");
    wr(AS, 8'h55, 0, 0, "R7 no restart");
    wr(AP, 8'hAA, 0, 1, "R7");
    wr(AS, 8'h55, 0, 1, "R7");
    wr(AP, 8'h80, 0, 1, "R7");
    wr(AP, 8'hAA, 0, 1, "R7");
    wr(AS, 8'h55, 0, 1, "R7");
    wr(AP, 8'h21, 0, 0, "R7 break clear");
    chk_prot(1, "R7 still protected");

    unlock_clear("R6");
    chk_prot(0, "R6");
    wr(15'h0500, 8'h33, 1, 0, "R6 open again");

    // armed write that looks like a command byte is data
    prefix("R3");
    wr(AP, 8'hAA, 1, 0, "R3 armed cmd-like data");
    chk_prot(1, "R3");

    @(negedge clk) rst_n = 1'b0;
    #1 chk(prot == 1'b0, "R1 reset clears", prot, 0);
    @(negedge clk) rst_n = 1'b1;
    wr(15'h0600, 8'h44, 1, 0, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule